// File: doc/BRIEF.md
# Carry Select Adder with Shared Half-Sum Stage

The block adds two unsigned operands and a carry-in, producing a sum of the operand width and a carry-out. It has no clock or state. It is built from 4-bit groups that are chained together: each group takes the carry-out of the group below it as its carry-in.

Each group works in five steps:
- One stage forms the per-bit half-sum as an XNOR and the per-bit generate as a NAND. Both come out in complemented polarity.
- A carry chain assumes the incoming carry is zero. It uses NOR logic and gives complemented carries.
- A second carry chain assumes the incoming carry is one and gives true carries.
- A NAND-based selector picks one carry vector using the real carry-in.
- One XNOR sum stage combines the selected carries with the complemented half-sums.

Both carry chains share the same half-sum and generate stage. The sum is formed only once, after selection, so no per-hypothesis sum logic is needed.

The operand width must be a multiple of four.

Top module: `csel_adder`

## Requirements
- R1: For a 4-bit instance, {carry_o, sum_o} equals a_i + b_i + carry_i for every combination of operands and carry-in.
- R2: For a wider instance, {carry_o, sum_o} equals a_i + b_i + carry_i. Carries ripple from group to group through the selected carry-out of each group.
- R3: For any fixed operands, carry_o with carry_i = 1 is never lower than carry_o with carry_i = 0. Inside each group, a carry asserted by the zero-hypothesis chain is also asserted by the one-hypothesis chain.
- R4: With carry_i = 1, the selected carries follow the one-hypothesis chain, and the result equals a_i + b_i + 1.
- R5: With carry_i = 0, the selected carries follow the zero-hypothesis chain, and the result equals a_i + b_i.
- R6: In a 4-bit instance, all-ones plus zero with carry_i = 1 wraps to sum 0 with carry_o = 1. All-ones plus all-ones with carry_i = 1 gives sum all-ones with carry_o = 1.
- R7: In a wide instance, an incoming carry propagates through every group. All-ones plus zero with carry_i = 1 gives sum 0 and carry_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| carry_i | input | 1 | Carry into the least significant group |
| sum_o | output | WIDTH | Sum bits, true polarity |
| carry_o | output | 1 | Carry out of the most significant group |

## Verification
The 4-bit instance is driven through all 512 operand and carry-in combinations. Each operand pair is applied first with carry-in 0 and then with carry-in 1. This separates faults in the zero-hypothesis chain from faults in the one-hypothesis chain and from faults in the selector polarity. It also shows whether the carry-out ever drops when the carry-in rises.

A 16-bit instance receives random operands plus full-propagate patterns. The random operands show whether each group's carry reaches the next group. The full-propagate patterns drive a carry across all groups. Together they expose a broken group link that a single 4-bit group cannot reveal.

// File: rtl/csel_adder.sv
module csel_adder #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  localparam int GW   = 4;
  localparam int NGRP = WIDTH / GW;

  for (genvar g = 0; g < NGRP; g++) begin : grp
    logic [GW-1:0] ga, gb;
    logic [GW-1:0] hs_n, gen_n;
    logic [GW-1:0] c0_n, c1;
    logic [GW-1:0] sel, s;
    logic          cin;

    assign ga = a_i[g*GW +: GW];
    assign gb = b_i[g*GW +: GW];

    if (g == 0) begin : g_first
      assign cin = carry_i;
    end else begin : g_next
      assign cin = grp[g-1].sel[GW-1];
    end

    always_comb begin
      // complemented half-sum and generate
      hs_n  = ~(ga ^ gb);
      gen_n = ~(ga & gb);

      // carry chains: zero hypothesis complemented, one hypothesis true
      c0_n[0] = gen_n[0];
      c1[0]   = ~(gen_n[0] & hs_n[0]);
      for (int i = 1; i < GW; i++) begin
        c0_n[i] = ~(~gen_n[i] | ~(hs_n[i] | c0_n[i-1]));
        c1[i]   = ~(gen_n[i] & (hs_n[i] | ~c1[i-1]));
      end

      for (int i = 0; i < GW; i++)
        sel[i] = ~(~(cin & c1[i]) & ~(~cin & ~c0_n[i]));

      s[0] = ~(hs_n[0] ^ cin);
      for (int i = 1; i < GW; i++)
        s[i] = ~(hs_n[i] ^ sel[i-1]);

      for (int i = 0; i < GW; i++) begin
        assert_c0_within_c1_R3: assert (c0_n[i] || c1[i])
          else $error("zero-hypothesis carry %0d set without one-hypothesis carry", i);
        if (cin) begin
          assert_pick_one_R4: assert (sel[i] == c1[i])
            else $error("selected carry %0d differs from one-hypothesis chain", i);
        end else begin
          assert_pick_zero_R5: assert (sel[i] == !c0_n[i])
            else $error("selected carry %0d differs from zero-hypothesis chain", i);
        end
      end
      assert_group_sum_R1: assert ({sel[GW-1], s} == ({1'b0, ga} + {1'b0, gb} + {{GW{1'b0}}, cin}))
        else $error("group %0d result mismatch", g);
    end

    assign sum_o[g*GW +: GW] = s;
  end

  assign carry_o = grp[NGRP-1].sel[GW-1];
endmodule

// File: tb/csel_adder_tb_top.sv
module csel_adder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WW = 16;

  typedef struct packed {
    logic [2:0]    ntag;
    logic [2:0]    wtag;
    logic [4:0]    nexp;
    logic [WW:0]   wexp;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0]    na, nb, nsum;
  logic          ncin, ncout;
  logic [WW-1:0] wa, wb, wsum;
  logic          wcin, wcout;

  csel_adder #(.WIDTH(4)) dut_i (
    .a_i(na), .b_i(nb), .carry_i(ncin), .sum_o(nsum), .carry_o(ncout));
  csel_adder #(.WIDTH(WW)) dut_w_i (
    .a_i(wa), .b_i(wb), .carry_i(wcin), .sum_o(wsum), .carry_o(wcout));

  item_t q[$];
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic last_c0_cout = 1'b0;

  function automatic string tname(input logic [2:0] t);
    case (t)
      3'd1: return "R1";
      3'd2: return "R2";
      3'd4: return "R4";
      3'd5: return "R5";
      3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input logic [3:0] a, input logic [3:0] b, input logic c,
                       input logic [WW-1:0] xa, input logic [WW-1:0] xb, input logic xc,
                       input logic [2:0] nt, input logic [2:0] wt);
    item_t it;
    @(negedge clk);
    na = a; nb = b; ncin = c;
    wa = xa; wb = xb; wcin = xc;
    it.ntag = nt;
    it.wtag = wt;
    it.nexp = {1'b0, a} + {1'b0, b} + {4'b0, c};
    it.wexp = {1'b0, xa} + {1'b0, xb} + {{WW{1'b0}}, xc};
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    if (rst_n && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if ({ncout, nsum} !== it.nexp) begin
        errors++;
        $display("FAIL %s narrow: got %h expected %h", tname(it.ntag), {ncout, nsum}, it.nexp);
      end
      // R3: cout with carry-in 1 not below cout with carry-in 0 for same operands
      if (it.ntag == 3'd5) last_c0_cout <= ncout;
      else if (it.ntag == 3'd4 || it.ntag == 3'd6) begin
        checks++;
        if (ncout < last_c0_cout) begin
          errors++;
          $display("FAIL R3: cout with carry-in 1 got %b, carry-in 0 gave %b", ncout, last_c0_cout);
        end
      end
      checks++;
      if ({wcout, wsum} !== it.wexp) begin
        errors++;
        $display("FAIL %s wide: got %h expected %h", tname(it.wtag), {wcout, wsum}, it.wexp);
      end
    end
  end

  initial begin
    na = '0; nb = '0; ncin = 1'b0; wa = '0; wb = '0; wcin = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R1, R4, R5, R6: exhaustive narrow, carry-in 0 then 1 per operand pair
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        for (int c = 0; c < 2; c++) begin
          logic [2:0] nt;
          if (c == 0) nt = 3'd5;
          else if ((a == 15 && (b == 0 || b == 15))) nt = 3'd6;
          else nt = 3'd4;
          apply(4'(a), 4'(b), c[0], WW'($urandom), WW'($urandom), 1'($urandom), nt, 3'd2);
        end
      end
    end
    // R7: full propagation across all wide groups
    apply(4'hF, 4'h0, 1'b1, {WW{1'b1}}, '0, 1'b1, 3'd6, 3'd7);
    apply(4'h0, 4'hF, 1'b1, '0, {WW{1'b1}}, 1'b1, 3'd6, 3'd7);
    apply(4'hF, 4'hF, 1'b1, {WW{1'b1}}, {WW{1'b1}}, 1'b1, 3'd6, 3'd7);
    apply(4'h0, 4'h0, 1'b0, 16'h0FFF, 16'h0001, 1'b0, 3'd5, 3'd7);
    // R2: more random wide vectors
    for (int k = 0; k < 200; k++)
      apply(4'h0, 4'h0, 1'b0, WW'($urandom), WW'($urandom), 1'($urandom), 3'd5, 3'd2);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule